// File: doc/BRIEF.md
# SDRAM Read/Write Command Scheduler with Burst Truncation

The scheduler takes column-access requests from a host over a valid/ready port and turns each one into a READ or WRITE on the command bus of a single-data-rate SDRAM. The target rows are assumed to be open already. The scheduler follows the read data that the memory will return under a CAS latency of 2 or 3, chosen at run time. It raises a read-data-valid strobe during exactly the cycles that carry wanted data. During write data cycles it raises the DQ output enable.

Every request carries a wanted-length count. A read asks for the first N elements of the burst, and anything after that is dropped. This happens in one of two ways. A later READ may be issued so that its first data directly follows the last wanted element, which cuts the old burst off. Or a WRITE may take over the data bus. A WRITE is held back until the read data has left the bus. If the bus handoff is marked unsafe, one extra idle cycle is inserted after the last read element. Reads can follow each other on every clock with no spacing rule.

Top module: `sdram_rd_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, the command bus shows NOP, `req_ready` is 1, and `rd_valid` and `dq_oe` are 0.
- R2: A request accepted at a clock edge puts its command on the bus in the cycle that follows that edge. READ is cs_n=0 ras_n=1 cas_n=0 we_n=1. WRITE is cs_n=0 ras_n=1 cas_n=0 we_n=0. Every other cycle shows NOP, which is cs_n=0 ras_n=1 cas_n=1 we_n=1.
- R3: With a command, `sd_addr` carries the column in bits COL_W-1..0 and the auto-precharge flag in bit AP_BIT (10 by default). `sd_ba` carries the bank. All other address bits are 0, and on NOP both buses are 0.
- R4: When a READ is on the bus in cycle k, `rd_valid` is high in cycles k+CL through k+CL+N-1. CL is 3 when `cl3`=1 and 2 when `cl3`=0.
- R5: The element count N equals `req_len`, except that a `req_len` of 0 or a value above BL gives N = BL.
- R6: A READ on the bus in cycle j ends any earlier burst. No data of the earlier burst is flagged in cycle j+CL or later.
- R7: Read requests are never stalled, so a READ can be issued on every clock.
- R8: When a WRITE is on the bus in cycle w, `dq_oe` is high in cycles w through w+N-1. A later command accepted before that window ends stops the window in the cycle where that command appears.
- R9: When the last flagged read element is in cycle L, a WRITE can first appear in cycle L+1 if `wr_safe`=1 and in cycle L+2 if `wr_safe`=0. `req_ready` is low while a write request is held back for this reason.
- R10: `cke` is always 1, and `dq_oe` and `rd_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cl3 | input | 1 | CAS latency select: 1 for three cycles, 0 for two |
| wr_safe | input | 1 | 1 allows a write directly after read data; 0 forces one idle cycle |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Scheduler can accept the presented request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Start column |
| req_ap | input | 1 | Auto-precharge flag |
| req_len | input | $clog2(BL)+1 | Wanted element count, 0 meaning full burst |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select strobe |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write-enable strobe |
| sd_addr | output | ADDR_W | Address bus: column and auto-precharge bit |
| sd_ba | output | BA_W | Bank address |
| dq_oe | output | 1 | Drive enable for write data |
| rd_valid | output | 1 | Flags a wanted read data element |

## Verification
Single reads are run at both latencies with lengths below BL, equal to BL, zero and above BL. These cases separate a wrong latency tap from a wrong length clamp. Reads are then issued every cycle and one cycle apart, with long bursts cut short by the next READ. This shows whether a newer burst overrides an older one or merges with it. Writes are queued straight behind reads in both handoff modes. The issue cycle then exposes a gap that is off by one or missing. Reads issued inside a write window show whether the output enable is cut off at the right cycle.

// File: rtl/sdram_rd_sched.sv
module sdram_rd_sched #(
  parameter int BL     = 4,
  parameter int COL_W  = 9,
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cl3,
  input  logic                      wr_safe,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [BA_W-1:0]           req_bank,
  input  logic [COL_W-1:0]          req_col,
  input  logic                      req_ap,
  input  logic [$clog2(BL):0]       req_len,
  output logic                      cke,
  output logic                      cs_n,
  output logic                      ras_n,
  output logic                      cas_n,
  output logic                      we_n,
  output logic [ADDR_W-1:0]         sd_addr,
  output logic [BA_W-1:0]           sd_ba,
  output logic                      dq_oe,
  output logic                      rd_valid
);
  localparam int LEN_W = $clog2(BL) + 1;
  localparam int TW    = LEN_W + 2;
  localparam logic [LEN_W-1:0] BL_V = LEN_W'(BL);

  logic [LEN_W-1:0]  n_len;
  logic              acc, acc_rd, acc_wr;
  logic [TW-1:0]     gap_q, gap_ld;
  logic [2:0]        pv;
  logic [LEN_W-1:0]  pl0, pl1, pl2;
  logic              tap_v;
  logic [LEN_W-1:0]  tap_l;
  logic [LEN_W-1:0]  rcnt, wcnt;
  logic [ADDR_W-1:0] a_nx;

  assign n_len  = (req_len == '0 || req_len > BL_V) ? BL_V : req_len;
  assign acc    = req_valid && req_ready;
  assign acc_rd = acc && !req_write;
  assign acc_wr = acc && req_write;

  assign gap_ld = (cl3 ? TW'(3) : TW'(2)) + TW'(n_len) - TW'(1)
                + (wr_safe ? TW'(0) : TW'(1));
  assign req_ready = !req_write || (gap_q == '0);

  assign tap_v = cl3 ? pv[2] : pv[1];
  assign tap_l = cl3 ? pl2 : pl1;

  assign cke      = 1'b1;
  assign cs_n     = 1'b0;
  assign ras_n    = 1'b1;
  assign rd_valid = (rcnt != '0);
  assign dq_oe    = (wcnt != '0);

  always_comb begin
    a_nx = '0;
    a_nx[COL_W-1:0] = req_col;
    a_nx[AP_BIT]    = req_ap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      pv    <= '0;
      pl0   <= '0;
      pl1   <= '0;
      pl2   <= '0;
      rcnt  <= '0;
      wcnt  <= '0;
    end else begin
      if (acc_rd)               gap_q <= gap_ld;
      else if (gap_q != '0)     gap_q <= gap_q - TW'(1);

      pv  <= {pv[1:0], acc_rd};
      pl0 <= n_len;
      pl1 <= pl0;
      pl2 <= pl1;

      if (tap_v)                rcnt <= tap_l;
      else if (rcnt != '0)      rcnt <= rcnt - LEN_W'(1);

      if (acc_wr)               wcnt <= n_len;
      else if (acc_rd)          wcnt <= '0;
      else if (wcnt != '0)      wcnt <= wcnt - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !acc) begin
      cas_n   <= 1'b1;
      we_n    <= 1'b1;
      sd_addr <= '0;
      sd_ba   <= '0;
    end else begin
      cas_n   <= 1'b0;
      we_n    <= !req_write;
      sd_addr <= a_nx;
      sd_ba   <= req_bank;
    end
  end
endmodule

// File: rtl/sdram_rd_sched_chk.sv
module sdram_rd_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_safe,
  input logic req_valid,
  input logic req_ready,
  input logic req_write,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic rd_valid
);
  a_r10_cke_high: assert property (@(posedge clk) disable iff (!rst_n) cke);

  a_r10_no_bus_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && rd_valid));

  a_r2_read_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (!cs_n && ras_n && !cas_n && we_n));

  a_r2_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write) |=> (!cs_n && ras_n && !cas_n && !we_n));

  a_r2_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!cs_n && ras_n && cas_n && we_n));

  a_r9_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n && !wr_safe) |-> (!rd_valid && !$past(rd_valid)));

  a_r8_oe_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n) |-> dq_oe);
endmodule

bind sdram_rd_sched sdram_rd_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_safe(wr_safe), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .cke(cke), .cs_n(cs_n),
  .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/sdram_rd_sched_tb.sv
module sdram_rd_sched_tb;
  localparam int BL = 4, COL_W = 9, BA_W = 2, ADDR_W = 12, AP_BIT = 10;
  localparam int LEN_W = $clog2(BL) + 1;
  localparam int DEPTH = 4096;

  logic clk = 0, rst_n = 0, cl3 = 0, wr_safe = 1;
  logic req_valid = 0, req_write = 0, req_ap = 0;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, cke, cs_n, ras_n, cas_n, we_n, dq_oe, rd_valid;
  logic [ADDR_W-1:0] sd_addr;
  logic [BA_W-1:0] sd_ba;

  always #4 clk = ~clk;

  sdram_rd_sched #(.BL(BL), .COL_W(COL_W), .BA_W(BA_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cl3(cl3), .wr_safe(wr_safe), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
    .req_ap(req_ap), .req_len(req_len), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .sd_addr(sd_addr), .sd_ba(sd_ba), .dq_oe(dq_oe),
    .rd_valid(rd_valid));

  bit exp_rd [DEPTH];
  bit exp_oe [DEPTH];
  int exp_cmd [DEPTH];
  int exp_addr [DEPTH];
  int exp_ba [DEPTH];
  int cyc = 0, last_l = -100, n_vec = 0, n_bad = 0;
  bit last_acc;

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int cmd_code();
    if (!cs_n && ras_n && !cas_n) return we_n ? 1 : 2;
    if (!cs_n && ras_n && cas_n && we_n) return 0;
    return 3;
  endfunction

  task automatic compare_outputs();
    check("R2 command", cmd_code(), exp_cmd[cyc]);
    check("R3 address", int'(sd_addr), exp_addr[cyc]);
    check("R3 bank", int'(sd_ba), exp_ba[cyc]);
    check("R4 R5 R6 R7 rd_valid", int'(rd_valid), int'(exp_rd[cyc]));
    check("R8 dq_oe", int'(dq_oe), int'(exp_oe[cyc]));
    check("R10 cke", int'(cke), 1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic tick();
    int cl, gap, k, n;
    bit mready;
    #1;
    cl  = cl3 ? 3 : 2;
    gap = wr_safe ? 0 : 1;
    mready = !req_write || (cyc + 1 > last_l + gap);
    check("R9 req_ready", int'(req_ready), int'(mready));
    last_acc = req_valid && mready;
    if (last_acc) begin
      k = cyc + 1;
      n = (req_len == 0 || req_len > BL) ? BL : int'(req_len);
      exp_cmd[k]  = req_write ? 2 : 1;
      exp_addr[k] = int'(req_col) | (int'(req_ap) << AP_BIT);
      exp_ba[k]   = int'(req_bank);
      for (int j = k; j < DEPTH; j++) exp_oe[j] = 0;
      if (req_write) begin
        for (int i = 0; i < n; i++) exp_oe[k + i] = 1;
      end else begin
        for (int j = k + cl; j < DEPTH; j++) exp_rd[j] = 0;
        for (int i = 0; i < n; i++) exp_rd[k + cl + i] = 1;
        last_l = k + cl + n - 1;
      end
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    if (cyc > DEPTH - 40) begin
      check("watchdog", 1, 0);
      finish_run();
    end
    compare_outputs();
  endtask

  task automatic idle(input int n);
    req_valid = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic send(input bit wr, input int bank, input int col, input bit ap, input int len);
    int tries = 0;
    req_valid = 1; req_write = wr; req_bank = BA_W'(bank);
    req_col = COL_W'(col); req_ap = ap; req_len = LEN_W'(len);
    do begin
      tick();
      tries++;
      if (tries > 40) begin
        check("R9 stalled request", 0, 1);
        finish_run();
      end
    end while (!last_acc);
    req_valid = 0;
    req_write = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset cmd", cmd_code(), 0);
    check("R1 reset rd_valid", int'(rd_valid), 0);
    check("R1 reset dq_oe", int'(dq_oe), 0);
    check("R1 reset ready", int'(req_ready), 1);
    rst_n = 1;
    cyc = 0;
    #1 compare_outputs();
    idle(2);

    cl3 = 0;
    send(0, 1, 9'h023, 0, 0);
    idle(8);
    cl3 = 1;
    send(0, 2, 9'h1ff, 1, 2);
    idle(8);
    send(0, 3, 9'h100, 1, 7);
    idle(10);

    cl3 = 0;
    send(0, 0, 1, 0, 0);
    send(0, 1, 2, 1, 0);
    send(0, 2, 3, 0, 1);
    send(0, 3, 4, 1, 0);
    idle(10);
    cl3 = 1;
    send(0, 0, 5, 0, 0);
    idle(1);
    send(0, 0, 6, 0, 3);
    idle(10);

    wr_safe = 1; cl3 = 0;
    send(0, 1, 7, 0, 2);
    send(1, 1, 8, 1, 0);
    idle(8);
    wr_safe = 0;
    send(0, 2, 9, 0, 2);
    send(1, 2, 10, 0, 1);
    idle(8);
    cl3 = 1;
    send(0, 3, 11, 1, 4);
    send(1, 3, 12, 1, 3);
    idle(8);

    wr_safe = 1; cl3 = 0;
    send(1, 0, 13, 0, 0);
    idle(1);
    send(0, 0, 14, 0, 1);
    idle(8);
    send(1, 1, 15, 0, 0);
    send(1, 1, 16, 1, 2);
    idle(10);

    finish_run();
  end
endmodule